// File: doc/BRIEF.md
# Polarity-Configurable Interrupt Aggregator

This block gathers a set of interrupt request lines arriving from a low-pin-count peripheral side and merges them into one level-high interrupt for a parent controller. Each line is first brought into the local clock domain by a synchroniser. A per-line sense bit then decides whether a high or a low level counts as "active". A small per-line state machine records the request as pending, either on an inactive-to-active transition (edge mode) or for as long as the line is active (level mode).

Software drives the block through a 32-bit word register interface with separate read and write strobes. That interface exposes a global control word (master enable and capture mode), a per-line enable mask, the read-only pending status, a write-ones-to-clear window and the per-line sense register. The parent interrupt is high whenever the master enable is set and at least one enabled line is pending.

Each per-line state machine has two named states. `SRC_IDLE` means nothing is recorded and `SRC_PEND` means a request is recorded. In edge mode, the transition *arm* (IDLE→PEND) happens on an inactive-to-active change. The transition *release* (PEND→IDLE) happens on a clear that does not coincide with a new change. In level mode, *arm* happens whenever the line is active and *release* happens whenever it is inactive.

Top module: `irqagg_top`

## Requirements
- R1: After reset, the control, enable, status and sense registers read 0 and `irq_o` is low (status reads 0 once lines held at their inactive level have passed the synchroniser).
- R2: Registers are selected by byte offset (`addr_i[4:2]`): 0x00 control, 0x04 enable, 0x08 status, 0x0C clear, 0x10 sense. A read returns the value on `rdata_o` one clock after the read strobe.
- R3: Control bit 31 is the master enable. While it is 0, `irq_o` stays low whatever is pending.
- R4: A sense bit of 1 makes its line active-high, and 0 makes it active-low. A change on a line reaches the status register on the third rising clock edge after the change.
- R5: When control bit 30 is 1 (edge mode), a status bit sets on an inactive-to-active transition of its line and stays set after the line returns to inactive, until it is cleared.
- R6: In edge mode, writing a 1 to a bit of the clear register (offset 0x0C, bits 17:0) clears that status bit. Writing 0 leaves the bit unchanged.
- R7: In edge mode, if a new inactive-to-active transition and a clear of the same bit land on the same clock edge, the status bit ends up set.
- R8: When control bit 30 is 0 (level mode), a status bit equals the active state of its line. A clear written while the line is active leaves the bit set.
- R9: `irq_o` is high exactly when the master enable is 1 and the AND of enable and status is non-zero.
- R10: The enable and sense registers read back what was written in bits 17:0, and their bits 31:18 read 0. Control reads back only bits 31 and 30.
- R11: The status register ignores writes, and the clear register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 18 | Raw interrupt request lines (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the clock after `rd_en_i` |
| irq_o | output | 1 | Level-high interrupt to the parent controller |

## Verification
The bench builds the block with its defaults: 18 lines and a two-stage synchroniser. With 18 lines, the highest line (bit 17) coincides with the top of the clear window, and bits 31:18 of every register are reachable as bits that must read 0. The two-stage depth fixes the three-edge latency that the bench relies on to place a new transition and a clear on the same edge. The reference model also runs every clock through a random phase in which the sense bits, the mode and the clears change while lines toggle, including mode switches with requests already pending.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // Register selectors, word index = byte offset / 4 (R2)
    localparam logic [2:0] SEL_CTL = 3'd0;
    localparam logic [2:0] SEL_ENA = 3'd1;
    localparam logic [2:0] SEL_STS = 3'd2;
    localparam logic [2:0] SEL_CLR = 3'd3;
    localparam logic [2:0] SEL_SNS = 3'd4;

    // Control word bit positions
    localparam int GIE_BIT  = 31;
    localparam int EDGE_BIT = 30;

    // Per-line capture state
    typedef enum logic {
        SRC_IDLE = 1'b0,
        SRC_PEND = 1'b1
    } src_state_e;

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int WIDTH  = 18,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) stage_q[0] <= '0;
                    else         stage_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) stage_q[s] <= '0;
                    else         stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/irqagg_srcfsm.sv
module irqagg_srcfsm
    import irqagg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    input  logic sense_i,
    input  logic edge_mode_i,
    input  logic clr_i,
    output logic pend_o
);
    src_state_e state_q, state_d;
    logic       prev_act_q;
    logic       act;
    logic       rise;

    // R4: sense bit 1 = active-high, 0 = active-low
    assign act  = sense_i ? line_i : ~line_i;
    assign rise = act & ~prev_act_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_act_q <= 1'b0;
        else         prev_act_q <= act;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE: begin
                if (edge_mode_i) begin
                    if (rise) state_d = SRC_PEND;        // arm on transition
                end else begin
                    if (act)  state_d = SRC_PEND;        // arm on level
                end
            end
            SRC_PEND: begin
                if (edge_mode_i) begin
                    if (clr_i && !rise) state_d = SRC_IDLE;  // release, set wins
                end else begin
                    if (!act) state_d = SRC_IDLE;            // release on level
                end
            end
            default: state_d = SRC_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= SRC_IDLE;
        else         state_q <= state_d;
    end

    // Output process
    always_comb begin
        pend_o = (state_q == SRC_PEND);
    end

    // R5
    edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_mode_i && pend_o && !clr_i) |=> pend_o);

    // R8
    level_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!edge_mode_i) |=> (pend_o == $past(act)));

    // R7
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_mode_i && clr_i && act && !prev_act_q) |=> pend_o);

endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int NSRC   = 18,
    parameter int ADDR_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [NSRC-1:0]   status_i,
    output logic [31:0]       rdata_o,
    output logic              gie_o,
    output logic              edge_o,
    output logic [NSRC-1:0]   ena_o,
    output logic [NSRC-1:0]   sense_o,
    output logic [NSRC-1:0]   clr_o
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [31:0] VALID_MASK = (NSRC >= 32) ? 32'hFFFF_FFFF
                                                      : ((32'd1 << NSRC) - 32'd1);

    logic [IDX_W-1:0] idx;
    logic             gie_q, edge_q;
    logic [NSRC-1:0]  ena_q, sense_q;
    logic [31:0]      rd_mux;
    logic [31:0]      rdata_q;
    logic             unused_bits;

    assign idx = addr_i[ADDR_W-1:2];
    assign unused_bits = ^{addr_i[1:0], wdata_i};

    // R2: write decode
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gie_q   <= 1'b0;
            edge_q  <= 1'b0;
            ena_q   <= '0;
            sense_q <= '0;
        end else if (wr_en_i) begin
            if (idx == IDX_W'(SEL_CTL)) begin
                gie_q  <= wdata_i[GIE_BIT];
                edge_q <= wdata_i[EDGE_BIT];
            end
            if (idx == IDX_W'(SEL_ENA)) ena_q   <= wdata_i[NSRC-1:0];
            if (idx == IDX_W'(SEL_SNS)) sense_q <= wdata_i[NSRC-1:0];
        end
    end

    // R6: clear pulse only on a write to the clear window
    always_comb begin
        clr_o = '0;
        if (wr_en_i && idx == IDX_W'(SEL_CLR)) clr_o = wdata_i[NSRC-1:0];
    end

    // R10, R11: read mux, unused bits read 0
    always_comb begin
        rd_mux = '0;
        if (idx == IDX_W'(SEL_CTL)) begin
            rd_mux[GIE_BIT]  = gie_q;
            rd_mux[EDGE_BIT] = edge_q;
        end else if (idx == IDX_W'(SEL_ENA)) begin
            rd_mux[NSRC-1:0] = ena_q;
        end else if (idx == IDX_W'(SEL_STS)) begin
            rd_mux[NSRC-1:0] = status_i;
        end else if (idx == IDX_W'(SEL_SNS)) begin
            rd_mux[NSRC-1:0] = sense_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rd_mux;
    end

    assign rdata_o = rdata_q;
    assign gie_o   = gie_q;
    assign edge_o  = edge_q;
    assign ena_o   = ena_q;
    assign sense_o = sense_q;

    // R10
    upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && (idx == IDX_W'(SEL_ENA) || idx == IDX_W'(SEL_SNS)))
        |=> ((rdata_o & ~VALID_MASK) == 32'd0));

    // R11
    status_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && idx == IDX_W'(SEL_STS))
        |=> ($stable(ena_q) && $stable(sense_q) && $stable(gie_q) && $stable(edge_q)));

    // R11
    clr_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && idx == IDX_W'(SEL_CLR)) |=> (rdata_o == 32'd0));

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int NSRC        = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] req_i,
    input  logic            wr_en_i,
    input  logic            rd_en_i,
    input  logic [4:0]      addr_i,
    input  logic [31:0]     wdata_i,
    output logic [31:0]     rdata_o,
    output logic            irq_o
);
    logic [NSRC-1:0] line_sync;
    logic [NSRC-1:0] status;
    logic [NSRC-1:0] ena, sense, clr;
    logic            gie, edge_mode;

    irqagg_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (req_i),
        .sync_o  (line_sync)
    );

    irqagg_regs #(.NSRC(NSRC), .ADDR_W(5)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .status_i (status),
        .rdata_o  (rdata_o),
        .gie_o    (gie),
        .edge_o   (edge_mode),
        .ena_o    (ena),
        .sense_o  (sense),
        .clr_o    (clr)
    );

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            irqagg_srcfsm u_fsm (
                .clk_i       (clk_i),
                .rst_ni      (rst_ni),
                .line_i      (line_sync[i]),
                .sense_i     (sense[i]),
                .edge_mode_i (edge_mode),
                .clr_i       (clr[i]),
                .pend_o      (status[i])
            );
        end
    endgenerate

    // R9: merged level output
    always_comb begin
        irq_o = gie & (|(ena & status));
    end

    // R3
    gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!gie) |-> !irq_o);

    // R9
    irq_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_o) |-> (!gie || ((ena & status) == '0)));

endmodule

// File: tb/irqagg_top_test.sv
module irqagg_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 18;
    localparam logic [31:0] MASK = 32'h0003_FFFF;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] req = '1;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [4:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            irq;

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    irqagg_top uut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_en_i(wr_en),
        .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    // Behavioural reference model
    logic [NSRC-1:0] m_s1, m_s2, m_prev, m_sts, m_en, m_pol;
    logic            m_gie, m_edge;
    logic [31:0]     m_rd;
    bit              m_rd_new;

    always @(posedge clk or negedge rst_n) begin
        logic [NSRC-1:0] act, clrv;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_sts = '0;
            m_en = '0; m_pol = '0; m_gie = 0; m_edge = 0;
            m_rd = '0; m_rd_new = 0;
        end else begin
            m_rd_new = rd_en;
            if (rd_en) begin
                case (addr >> 2)
                    0: m_rd = {m_gie, m_edge, 30'd0};
                    1: m_rd = 32'(m_en);
                    2: m_rd = 32'(m_sts);
                    4: m_rd = 32'(m_pol);
                    default: m_rd = 32'd0;
                endcase
            end
            act  = (m_s2 & m_pol) | (~m_s2 & ~m_pol);
            clrv = (wr_en && (addr >> 2) == 3) ? wdata[NSRC-1:0] : '0;
            if (m_edge) m_sts = (act & ~m_prev) | (m_sts & ~clrv);
            else        m_sts = act;
            m_prev = act;
            m_s2 = m_s1;
            m_s1 = req;
            if (wr_en) begin
                case (addr >> 2)
                    0: begin m_gie = wdata[31]; m_edge = wdata[30]; end
                    1: m_en  = wdata[NSRC-1:0];
                    4: m_pol = wdata[NSRC-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (irq !== (m_gie & (|(m_en & m_sts)))) begin
                failures++;
                $display("FAIL R9 (%s) irq actual=%0b expected=%0b", tag, irq,
                         m_gie & (|(m_en & m_sts)));
            end
            if (m_rd_new) begin
                checks++;
                if (rdata !== m_rd) begin
                    failures++;
                    $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, m_rd);
                end
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic expect_rd(input logic [4:0] a, input logic [31:0] exp, input string t);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0;
        checks++;
        if (rdata !== exp) begin
            failures++;
            $display("FAIL %s read @%h actual=%h expected=%h", t, a, rdata, exp);
        end
    endtask

    task automatic expect_irq(input logic exp, input string t);
        @(negedge clk);
        checks++;
        if (irq !== exp) begin
            failures++;
            $display("FAIL %s irq actual=%0b expected=%0b", t, irq, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset with lines at inactive level (active-low default)
        idle(3);
        rst_n = 1;
        idle(5);
        expect_rd(5'h00, 32'h0, "R1");
        expect_rd(5'h04, 32'h0, "R1");
        expect_rd(5'h08, 32'h0, "R1");
        expect_rd(5'h10, 32'h0, "R1");
        expect_irq(1'b0, "R1");

        // R10, R2
        tag = "R10";
        wr(5'h04, 32'hFFFF_FFFF);
        expect_rd(5'h04, MASK, "R10");
        wr(5'h10, 32'hFFF0_0005);
        expect_rd(5'h10, 32'h0000_0005, "R10");
        wr(5'h00, 32'hFFFF_FFFF);
        expect_rd(5'h00, 32'hC000_0000, "R2");
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h0);

        // R4, R8: level mode, active-high lines
        tag = "R8";
        wr(5'h10, MASK);
        @(negedge clk); req = '0;
        idle(4);
        expect_rd(5'h08, 32'h0, "R4");
        @(negedge clk); req[3] = 1'b1;
        idle(3);
        expect_rd(5'h08, 32'h8, "R4");
        wr(5'h0C, 32'h8);
        expect_rd(5'h08, 32'h8, "R8");
        @(negedge clk); req[3] = 1'b0;
        idle(3);
        expect_rd(5'h08, 32'h0, "R8");
        // active-low on line 5
        wr(5'h10, MASK & ~32'h20);
        idle(3);
        expect_rd(5'h08, 32'h20, "R4");
        wr(5'h10, MASK);
        idle(3);

        // R3, R9: master enable gating
        tag = "R3";
        wr(5'h04, 32'h8);
        @(negedge clk); req[3] = 1'b1;
        idle(4);
        expect_irq(1'b0, "R3");
        wr(5'h00, 32'h8000_0000);
        expect_irq(1'b1, "R9");
        wr(5'h04, 32'h10);
        expect_irq(1'b0, "R9");
        @(negedge clk); req[3] = 1'b0;
        idle(3);

        // R5, R6: edge mode
        tag = "R5";
        wr(5'h00, 32'hC000_0000);
        wr(5'h0C, MASK);
        expect_rd(5'h08, 32'h0, "R5");
        @(negedge clk); req[7] = 1'b1;
        @(negedge clk); req[7] = 1'b0;
        idle(4);
        expect_rd(5'h08, 32'h80, "R5");
        wr(5'h0C, 32'h0);
        expect_rd(5'h08, 32'h80, "R6");
        wr(5'h0C, 32'h80);
        expect_rd(5'h08, 32'h0, "R6");

        // R7: new transition and clear on the same edge
        tag = "R7";
        @(negedge clk); req[9] = 1'b1;
        @(negedge clk);
        wr(5'h0C, 32'h200);
        expect_rd(5'h08, 32'h200, "R7");
        @(negedge clk); req[9] = 1'b0;
        idle(3);
        wr(5'h0C, 32'h200);
        expect_rd(5'h08, 32'h0, "R7");

        // R11: status ignores writes, clear reads 0
        tag = "R11";
        @(negedge clk); req[17] = 1'b1;
        idle(4);
        wr(5'h08, 32'h0);
        expect_rd(5'h08, 32'h2_0000, "R11");
        wr(5'h08, 32'hFFFF_FFFF);
        expect_rd(5'h04, 32'h10, "R11");
        expect_rd(5'h0C, 32'h0, "R11");

        // Random phase compared against the model every clock (R9)
        tag = "R9";
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            req = NSRC'($urandom);
            wr_en = 0; rd_en = 0;
            case ($urandom % 6)
                0: begin wr_en = 1; addr = 5'h0C; wdata = $urandom; end
                1: begin wr_en = 1; addr = 5'h04; wdata = $urandom; end
                2: begin wr_en = 1; addr = 5'h10; wdata = $urandom; end
                3: begin wr_en = 1; addr = 5'h00; wdata = {2'($urandom), 30'd0}; end
                default: begin rd_en = 1; addr = 5'(($urandom % 5) << 2); end
            endcase
        end
        @(negedge clk); wr_en = 0; rd_en = 0;
        idle(2);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule